// File: doc/BRIEF.md
# Bit-Masked B-Channel Serial Port

This block is a frame-synchronous serial transceiver for an 8 kHz ISDN-style frame that carries two 8-bit bearer channels, called B1 and B2. A 16-bit mask selects individual bit slots inside the two channels. Each selected slot can then act as its own 8 kbps sub-channel for rate adaptation. Received bits from selected slots are packed into one parallel byte per channel. Bytes to send are taken from one holding input per channel, and only the selected slots consume them. In every other slot the transmit line is released. Two strobes mark the selected slots of B1 and B2, so a device that does not speak the frame protocol can still find its data bits.

All logic runs on the serial bit clock, and each clock is one bit slot. A one-cycle frame sync marks slot 0 of a frame. Slots 0 to 7 belong to B1 and slots 8 to 15 to B2, each channel most significant bit first. Slots 16 and later carry no bearer traffic. The mask and both transmit bytes are sampled in the sync cycle, and they hold for that whole frame.

Top module: `bchan_mask_port`

## Requirements
- R1: While reset is asserted, and after reset until the first frame sync, `txd`, `txd_oe`, both strobes, both valid flags and both receive bytes are 0.
- R2: The cycle in which `fsync` is high is slot 0, and each later cycle is the next slot. In slot s (0 to 15), the mask bit `mask_cfg[15-s]` enables that slot. `strb_b1` is high only in enabled slots 0 to 7, and `strb_b2` is high only in enabled slots 8 to 15.
- R3: `txd_oe` is high exactly in the enabled slots of either channel. `txd` is 0 whenever `txd_oe` is low.
- R4: In the k-th enabled slot of a channel within one frame (k from 1), `txd` carries bit 8-k of that channel's transmit byte. That byte is sampled in the sync cycle, and later changes to `tx_b1` or `tx_b2` have no effect until the next sync.
- R5: The bits received in a channel's enabled slots are shifted in at the least significant end, in arrival order, and the unused upper bits are 0. The resulting byte appears on `rx_b1` one cycle after slot 7, and on `rx_b2` one cycle after slot 15. The matching valid flag is high for exactly that one cycle. Otherwise the receive byte holds its value.
- R6: The mask is sampled only in the sync cycle. A change of `mask_cfg` during a frame has no effect until the next sync.
- R7: From slot 16 on, and after the slot count reaches `FRAME_SLOTS` with no new sync, no strobe, output enable or receive capture occurs.
- R8: A sync that arrives before the current frame ends restarts the frame at slot 0 and discards the channel that was only partly received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, one bit slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; high in slot 0 |
| rxd | input | 1 | Serial receive data |
| mask_cfg | input | 16 | Slot enables; bit 15-s enables slot s |
| tx_b1 | input | 8 | B1 transmit holding byte |
| tx_b2 | input | 8 | B2 transmit holding byte |
| txd | output | 1 | Serial transmit data, 0 when not driven |
| txd_oe | output | 1 | Output enable for the transmit pad |
| strb_b1 | output | 1 | Data strobe for enabled B1 slots |
| strb_b2 | output | 1 | Data strobe for enabled B2 slots |
| rx_b1 | output | 8 | Packed B1 receive byte |
| rx_b2 | output | 8 | Packed B2 receive byte |
| rx_b1_vld | output | 1 | One-cycle pulse when rx_b1 updates |
| rx_b2_vld | output | 1 | One-cycle pulse when rx_b2 updates |

## Verification
The hardest case to reach is a frame in which the sampled mask and transmit bytes differ from the values on the inputs. The stimulus changes `tx_b1` and `mask_cfg` partway through a frame and keeps the new values for the next one. This shows that the old values stay in force until the next sync and that the new ones take over only there. A second hard case is a sync that arrives in the middle of B2. The stimulus cuts a frame short at slot 10, and then confirms that no B2 byte is delivered and that the next frame starts its packing from zero. Random masks and data across many frames then cover sparse and dense slot patterns in both channels.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  parameter int unsigned CH_BITS = 8;
  parameter int unsigned NUM_CH  = 2;
  localparam int unsigned MASK_W = CH_BITS * NUM_CH;
  typedef logic [CH_BITS-1:0] chbyte_t;
endpackage

// File: rtl/bmp_rst_sync.sv
module bmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bmp_slot_timer.sv
module bmp_slot_timer #(
  parameter int unsigned FRAME_SLOTS = 32,
  parameter int unsigned SLOT_W      = 6,
  parameter int unsigned MASK_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [MASK_W-1:0] mask_cfg,
  output logic [SLOT_W-1:0] slot,
  output logic [MASK_W-1:0] mask_act
);
  localparam logic [SLOT_W-1:0] IDLE = SLOT_W'(FRAME_SLOTS);

  logic [SLOT_W-1:0] cnt_q, cnt_n;
  logic [MASK_W-1:0] mask_q;

  // the sync cycle itself is slot 0, so sync bypasses the registers
  always_comb begin
    slot     = fsync ? '0 : cnt_q;
    cnt_n    = (slot == IDLE) ? IDLE : slot + 1'b1;
    mask_act = fsync ? mask_cfg : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= IDLE;
      mask_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (fsync) mask_q <= mask_cfg;
    end
  end
endmodule

// File: rtl/bmp_chan.sv
module bmp_chan
  import bmp_pkg::*;
#(
  parameter int unsigned BASE   = 0,
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] slot,
  input  chbyte_t           mask_slice,
  input  chbyte_t           hold,
  input  logic              rxd,
  output logic              en,
  output logic              tx_bit,
  output chbyte_t           rx_data,
  output logic              rx_vld
);
  localparam int unsigned       POS_W = $clog2(CH_BITS);
  localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(BASE);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(BASE + CH_BITS - 1);

  logic              in_ch, at_last;
  logic [SLOT_W-1:0] pos_full;
  logic [POS_W-1:0]  idx;
  chbyte_t           tx_src, tx_sh_q, tx_sh_n;
  chbyte_t           rx_base, rx_sh_q, rx_sh_n;
  chbyte_t           rx_data_q;
  logic              rx_vld_q;

  always_comb begin
    in_ch    = (slot >= FIRST) && (slot <= LAST);
    at_last  = (slot == LAST);
    pos_full = slot - FIRST;
    idx      = POS_W'(CH_BITS - 1) - pos_full[POS_W-1:0];
    en       = in_ch && mask_slice[idx];
    // transmit: byte reloaded at sync, enabled slots consume from the top
    tx_src   = fsync ? hold : tx_sh_q;
    tx_bit   = tx_src[CH_BITS-1];
    tx_sh_n  = en ? {tx_src[CH_BITS-2:0], 1'b0} : tx_src;
    // receive: packing restarts at the channel's first slot
    rx_base  = (slot == FIRST) ? '0 : rx_sh_q;
    rx_sh_n  = en ? {rx_base[CH_BITS-2:0], rxd} : rx_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_data_q <= '0;
      rx_vld_q  <= 1'b0;
    end else begin
      tx_sh_q <= tx_sh_n;
      if (in_ch)   rx_sh_q   <= rx_sh_n;
      if (at_last) rx_data_q <= rx_sh_n;
      rx_vld_q <= at_last;
    end
  end

  assign rx_data = rx_data_q;
  assign rx_vld  = rx_vld_q;
endmodule

// File: rtl/bchan_mask_port.sv
module bchan_mask_port
  import bmp_pkg::*;
#(
  parameter int unsigned FRAME_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              rxd,
  input  logic [MASK_W-1:0] mask_cfg,
  input  chbyte_t           tx_b1,
  input  chbyte_t           tx_b2,
  output logic              txd,
  output logic              txd_oe,
  output logic              strb_b1,
  output logic              strb_b2,
  output chbyte_t           rx_b1,
  output chbyte_t           rx_b2,
  output logic              rx_b1_vld,
  output logic              rx_b2_vld
);
  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS + 1);

  logic              rst_n_i;
  logic [SLOT_W-1:0] slot;
  logic [MASK_W-1:0] mask_act;
  chbyte_t           hold    [NUM_CH];
  chbyte_t           rx_data [NUM_CH];
  logic [NUM_CH-1:0] en, tx_bit, rx_vld;

  bmp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  bmp_slot_timer #(.FRAME_SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W), .MASK_W(MASK_W)) u_timer (
    .clk(clk), .rst_n(rst_n_i), .fsync(fsync), .mask_cfg(mask_cfg),
    .slot(slot), .mask_act(mask_act)
  );

  assign hold[0] = tx_b1;
  assign hold[1] = tx_b2;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmp_chan #(.BASE(c * CH_BITS), .SLOT_W(SLOT_W)) u_chan (
      .clk(clk), .rst_n(rst_n_i), .fsync(fsync), .slot(slot),
      .mask_slice(mask_act[MASK_W-1-c*CH_BITS -: CH_BITS]),
      .hold(hold[c]), .rxd(rxd),
      .en(en[c]), .tx_bit(tx_bit[c]), .rx_data(rx_data[c]), .rx_vld(rx_vld[c])
    );
  end

  // channels own disjoint slots, so at most one enable is high
  assign txd_oe    = |en;
  assign txd       = |(en & tx_bit);
  assign strb_b1   = en[0];
  assign strb_b2   = en[1];
  assign rx_b1     = rx_data[0];
  assign rx_b2     = rx_data[1];
  assign rx_b1_vld = rx_vld[0];
  assign rx_b2_vld = rx_vld[1];
endmodule

// File: rtl/bmp_checker.sv
module bmp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fsync,
  input logic [15:0] mask_cfg,
  input logic        txd,
  input logic        txd_oe,
  input logic        strb_b1,
  input logic        strb_b2,
  input logic [7:0]  rx_b1,
  input logic [7:0]  rx_b2,
  input logic        rx_b1_vld,
  input logic        rx_b2_vld
);
  // cycles since the last sync, saturating; independent slot tracker
  logic [5:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= 6'd63;
    else if (fsync)            since_q <= 6'd1;
    else if (since_q != 6'd63) since_q <= since_q + 6'd1;
  end

  p_b1_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb_b1 |-> (fsync || since_q < 6'd8));
  p_b2_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb_b2 |-> (!fsync && since_q >= 6'd8 && since_q < 6'd16));
  p_txd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> !txd);
  p_oe_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe |-> (strb_b1 || strb_b2));
  p_vld1_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_b1_vld |-> since_q == 6'd8);
  p_vld2_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_b2_vld |-> since_q == 6'd16);
  p_rx1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_b1_vld |-> $stable(rx_b1));
  p_rx2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_b2_vld |-> $stable(rx_b2));
  p_masked_b1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && mask_cfg[15:8] == 8'h00) |=> !strb_b1);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && since_q >= 6'd16) |-> !(strb_b1 || strb_b2 || txd_oe));
endmodule

bind bchan_mask_port bmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .mask_cfg(mask_cfg),
  .txd(txd), .txd_oe(txd_oe), .strb_b1(strb_b1), .strb_b2(strb_b2),
  .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_b1_vld(rx_b1_vld), .rx_b2_vld(rx_b2_vld)
);

// File: tb/test_bchan_mask_port.sv
module test_bchan_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        rxd = 1'b0;
  logic [15:0] mask_cfg = 16'h0000;
  logic [7:0]  tx_b1 = 8'h00, tx_b2 = 8'h00;
  logic        txd, txd_oe, strb_b1, strb_b2, rx_b1_vld, rx_b2_vld;
  logic [7:0]  rx_b1, rx_b2;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  string sc_tag = "R1";

  bchan_mask_port #(.FRAME_SLOTS(32)) i_bchan_mask_port (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .mask_cfg(mask_cfg),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .txd(txd), .txd_oe(txd_oe),
    .strb_b1(strb_b1), .strb_b2(strb_b2), .rx_b1(rx_b1), .rx_b2(rx_b2),
    .rx_b1_vld(rx_b1_vld), .rx_b2_vld(rx_b2_vld)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, sc_tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int        m_cnt = 32, k1 = 0, k2 = 0;
  logic [15:0] m_mask = 16'h0;
  logic [7:0]  m_t1 = 8'h0, m_t2 = 8'h0, e_rx1 = 8'h0, e_rx2 = 8'h0;
  bit        e_v1 = 0, e_v2 = 0;
  bit        q1[$], q2[$];

  function automatic logic [7:0] pack(input bit q[$]);
    logic [7:0] v = 8'h00;
    foreach (q[i]) v = {v[6:0], q[i]};
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: reset state
      chk({txd, txd_oe, strb_b1, strb_b2, rx_b1_vld, rx_b2_vld} == 6'b0, "R1 ctl", 0, 0);
      chk(rx_b1 == 8'h00 && rx_b2 == 8'h00, "R1 rx", {rx_b1, rx_b2}, 0);
      m_cnt = 32; m_mask = '0; e_rx1 = '0; e_rx2 = '0; e_v1 = 0; e_v2 = 0;
      k1 = 0; k2 = 0; q1.delete(); q2.delete();
    end else begin
      int  slot;
      bit  s1, s2, et;
      chk(rx_b1 == e_rx1, "R5 rx_b1", rx_b1, e_rx1);
      chk(rx_b2 == e_rx2, "R5 rx_b2", rx_b2, e_rx2);
      chk(rx_b1_vld == e_v1, "R5 vld1", rx_b1_vld, e_v1);
      chk(rx_b2_vld == e_v2, "R5 vld2", rx_b2_vld, e_v2);
      slot = fsync ? 0 : m_cnt;
      if (fsync) begin
        m_mask = mask_cfg; m_t1 = tx_b1; m_t2 = tx_b2; k1 = 0; k2 = 0;
      end
      s1 = (slot < 8) && m_mask[15 - slot];
      s2 = (slot >= 8) && (slot < 16) && m_mask[15 - slot];
      et = s1 ? m_t1[7 - k1] : (s2 ? m_t2[7 - k2] : 1'b0);
      chk(strb_b1 == s1, "R2 strb_b1", strb_b1, s1);
      chk(strb_b2 == s2, "R2 strb_b2", strb_b2, s2);
      chk(txd_oe == (s1 | s2), "R3 txd_oe", txd_oe, s1 | s2);
      chk(txd == et, "R4 txd", txd, et);
      if (s1) k1++;
      if (s2) k2++;
      if (slot == 0) q1.delete();
      if (slot == 8) q2.delete();
      if (s1) q1.push_back(rxd);
      if (s2) q2.push_back(rxd);
      e_v1 = (slot == 7);
      e_v2 = (slot == 15);
      if (slot == 7)  e_rx1 = pack(q1);
      if (slot == 15) e_rx2 = pack(q2);
      m_cnt = (slot == 32) ? 32 : slot + 1;
    end
  end

  task automatic drive(input bit fs);
    @(posedge clk); #1;
    fsync = fs;
    rxd   = 1'($urandom);
  endtask

  task automatic frame(input logic [15:0] m, input logic [7:0] a, input logic [7:0] b, input int len);
    @(posedge clk); #1;
    mask_cfg = m; tx_b1 = a; tx_b2 = b; fsync = 1'b1; rxd = 1'($urandom);
    for (int s = 1; s < len; s++) drive(1'b0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 12; i++) drive(1'b0);   // R1: quiet before first sync
    sc_tag = "R2";
    frame(16'hFFFF, 8'hA5, 8'h3C, 32);
    frame(16'h4229, 8'hC3, 8'h96, 32);          // two B1 bits, three B2 bits
    sc_tag = "R3";
    frame(16'h0000, 8'hFF, 8'hFF, 32);
    frame(16'h8001, 8'h80, 8'h01, 32);
    sc_tag = "R6";                               // also R4: mid-frame input changes
    @(posedge clk); #1;
    mask_cfg = 16'hF00F; tx_b1 = 8'hB4; tx_b2 = 8'h5A; fsync = 1'b1; rxd = 1'($urandom);
    for (int s = 1; s < 32; s++) begin
      drive(1'b0);
      if (s == 3) tx_b1 = 8'h4B;
      if (s == 5) mask_cfg = 16'h0FF0;
    end
    frame(16'h0FF0, 8'h4B, 8'hE7, 32);
    sc_tag = "R8";
    frame(16'hFFFF, 8'h12, 8'h34, 10);          // resync inside B2
    frame(16'h00FF, 8'h56, 8'h78, 32);
    sc_tag = "R7";
    frame(16'hFFFF, 8'h9A, 8'hBC, 20);
    for (int i = 0; i < 40; i++) drive(1'b0);   // counter saturates, stays idle
    sc_tag = "R4";
    for (int f = 0; f < 30; f++)
      frame(16'($urandom), 8'($urandom), 8'($urandom), 32);
    repeat (4) drive(1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule